// File: doc/BRIEF.md
# Symmetric-Coefficient FIR Filter Cell

This block is one streaming FIR filter cell for video-rate samples. It accepts one 10-bit sample per clock when `in_valid` is high and produces a full-precision 28-bit filtered result. Four multiply-add lanes sit behind a preadder. When the coefficient set is symmetric, the preadder folds mirrored taps together, so the four lanes realise an 8-tap filter. When the set is not symmetric, the preadder is bypassed and the lanes realise a 4-tap filter.

Coefficients are held in a bank of 32 selectable sets of eight 10-bit words. A write port loads the bank, and a set-select input travels with every sample, so the active set can change from one sample to the next. Two format bits state whether samples and coefficients are unsigned or two's complement, and each bit is independent of the other. The output stage can round the result to a chosen width and can thin the valid flag by a decimation factor.

The datapath has five registered stages. The first register takes the sample, its controls and the four coefficients. Next come the preadder, the product, the sum, and the round and decimate stage. No state machine is needed: every stage advances on the valid bit it carries.

Top module: `fir_sym_cell`

## Requirements
- R1: `data_signed`=1 treats `in_data` as two's complement and 0 treats it as unsigned. `coef_signed` selects the coefficient format in the same way. The two bits are independent, so unsigned, signed and mixed products are all correct.
- R2: With `sym_mode`=1, the result for the newest sample x[n] is the sum over k=0..3 of c[k]·(x[n-k] + x[n-7+k]). Here c[k] is word k of the selected set.
- R3: With `sym_mode`=0, the result is the sum over k=0..3 of c[k]·x[n-k]. The older samples x[n-4]..x[n-7] have no effect.
- R4: A write with `cw_en`=1 stores `cw_data` at word `cw_idx` of set `cw_set`. A sample taken on the same edge as the write still uses the old word, and later samples use the new one. Words 4..7 are stored but never enter the arithmetic.
- R5: `set_sel` is sampled together with each sample and picks that sample's coefficient set. It may change on every sample.
- R6: A sample taken on clock edge k yields its result with `out_valid` high just after edge k+4, in every mode.
- R7: With `round_en`=1 and W = `round_width` clamped to 8..19, `out_data` is floor((acc + 2^(27-W)) / 2^(28-W)), sign-extended to 28 bits. With `round_en`=0, `out_data` is the exact 28-bit two's complement sum. The rounding controls travel with the sample.
- R8: With D = `decim` clamped to 1..16 (0 acts as 1), the first result after reset is flagged valid, and after that every Dth result is flagged.
- R9: `out_data` changes only on a cycle with `out_valid` high and holds its value otherwise. A cycle with `in_valid` low neither shifts the delay line nor produces a result.
- R10: Synchronous reset clears the delay line to zeros, the decimation count and all results in flight. It drives `out_valid` and `out_data` to 0. The coefficient bank keeps its contents through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present this cycle |
| in_data | input | 10 | Input sample |
| set_sel | input | 5 | Coefficient set for this sample |
| sym_mode | input | 1 | 1: fold mirrored taps (8 taps); 0: direct (4 taps) |
| data_signed | input | 1 | Sample format: 1 two's complement, 0 unsigned |
| coef_signed | input | 1 | Coefficient format: 1 two's complement, 0 unsigned |
| round_en | input | 1 | Enable rounding of the result |
| round_width | input | 5 | Rounded width, clamped to 8..19 |
| decim | input | 5 | Decimation factor, clamped to 1..16 |
| cw_en | input | 1 | Coefficient write strobe |
| cw_set | input | 5 | Set written |
| cw_idx | input | 3 | Word within the set |
| cw_data | input | 10 | Coefficient value |
| out_valid | output | 1 | Result flagged valid |
| out_data | output | 28 | Result, full precision or rounded and sign-extended |

## Verification
On every cycle, the assertions check four things:
- the reset clearing of the outputs;
- that a flagged result always traces back to a sample exactly five samples of edges earlier, with no reset in between;
- that at a decimation factor of one, every sample produces a flagged result;
- that `out_data` never moves without `out_valid`, and that a rounded result always fits its signed width.

The arithmetic itself can only be shown by the bench scenarios, which compare every cycle against a behavioural convolution. That covers the folded and direct sums, the mixed-format products, set switching, and the ordering of a write against a sample on the same edge. The scenarios also cover decimation phase across reset and the retention of coefficients after reset.

// File: rtl/fir_cell_pkg.sv
package fir_cell_pkg;

    localparam int SAMPLE_W = 10;
    localparam int COEF_W   = 10;
    localparam int N_SETS   = 32;
    localparam int SET_LEN  = 8;
    localparam int N_MUL    = 4;
    localparam int ACC_W    = 28;
    localparam int CFG_W    = 5;
    localparam int RW_MIN   = 8;
    localparam int RW_MAX   = 19;
    localparam int DEC_MAX  = 16;

    typedef struct packed {
        logic             en;
        logic [CFG_W-1:0] width;
    } rnd_cfg_t;

    typedef struct packed {
        logic     sym;
        logic     x_sgn;
        logic     c_sgn;
        rnd_cfg_t rnd;
    } lane_ctl_t;

    function automatic logic [CFG_W-1:0] clamp_width(input logic [CFG_W-1:0] w);
        if (w < CFG_W'(RW_MIN)) return CFG_W'(RW_MIN);
        if (w > CFG_W'(RW_MAX)) return CFG_W'(RW_MAX);
        return w;
    endfunction

    function automatic logic [CFG_W-1:0] clamp_decim(input logic [CFG_W-1:0] d);
        if (d == '0) return CFG_W'(1);
        if (d > CFG_W'(DEC_MAX)) return CFG_W'(DEC_MAX);
        return d;
    endfunction

endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
    parameter int CW   = 10,
    parameter int NSET = 32,
    parameter int SLEN = 8,
    parameter int NRD  = 4,
    localparam int SELW = $clog2(NSET),
    localparam int IDXW = $clog2(SLEN)
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [SELW-1:0]         wr_set,
    input  logic [IDXW-1:0]         wr_idx,
    input  logic [CW-1:0]           wr_data,
    input  logic                    rd_en,
    input  logic [SELW-1:0]         rd_set,
    output logic [NRD-1:0][CW-1:0]  rd_coef
);

    logic [CW-1:0] mem [NSET][SLEN];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_set][wr_idx] <= wr_data;
        end
    end

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        always_ff @(posedge clk) begin
            if (rd_en) begin
                rd_coef[k] <= mem[rd_set][k];
            end
        end
    end

endmodule

// File: rtl/fir_tapline.sv
module fir_tapline
    import fir_cell_pkg::*;
#(
    parameter int DW   = 10,
    parameter int NTAP = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [DW-1:0]           in_data,
    input  lane_ctl_t               ctl_in,
    output logic [NTAP-1:0][DW-1:0] taps,
    output logic                    v_q,
    output lane_ctl_t               ctl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
            v_q  <= 1'b0;
        end else begin
            v_q <= in_valid;
            if (in_valid) begin
                taps <= {taps[NTAP-2:0], in_data};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            ctl_q <= ctl_in;
        end
    end

endmodule

// File: rtl/fir_mac.sv
module fir_mac
    import fir_cell_pkg::*;
#(
    parameter int DW   = 10,
    parameter int CW   = 10,
    parameter int NMUL = 4,
    parameter int ACCW = 28,
    localparam int XW  = DW + 1,
    localparam int PW  = DW + 2,
    localparam int KW  = CW + 1,
    localparam int MW  = PW + KW,
    localparam int SW  = MW + $clog2(NMUL)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        v_in,
    input  lane_ctl_t                   ctl_in,
    input  logic [2*NMUL-1:0][DW-1:0]   taps,
    input  logic [NMUL-1:0][CW-1:0]     coefs,
    output logic                        v_out,
    output rnd_cfg_t                    rnd_out,
    output logic [ACCW-1:0]             acc
);

    logic              v1, v2;
    rnd_cfg_t          r1, r2;
    logic signed [MW-1:0] prod_all [NMUL];
    logic signed [SW-1:0] sum;

    for (genvar k = 0; k < NMUL; k++) begin : g_lane
        logic signed [XW-1:0] xa, xb;
        logic signed [KW-1:0] ce;
        logic signed [PW-1:0] pre_q;
        logic signed [KW-1:0] ce_q;
        logic signed [MW-1:0] prod_q;

        always_comb begin
            xa = {ctl_in.x_sgn & taps[k][DW-1], taps[k]};
            xb = ctl_in.sym ? {ctl_in.x_sgn & taps[2*NMUL-1-k][DW-1], taps[2*NMUL-1-k]} : '0;
            ce = {ctl_in.c_sgn & coefs[k][CW-1], coefs[k]};
        end

        always_ff @(posedge clk) begin
            pre_q  <= PW'(xa) + PW'(xb);
            ce_q   <= ce;
            prod_q <= MW'(pre_q) * MW'(ce_q);
        end

        assign prod_all[k] = prod_q;
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < NMUL; k++) begin
            sum = sum + SW'(prod_all[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v1    <= 1'b0;
            v2    <= 1'b0;
            v_out <= 1'b0;
        end else begin
            v1    <= v_in;
            v2    <= v1;
            v_out <= v2;
        end
    end

    always_ff @(posedge clk) begin
        r1      <= ctl_in.rnd;
        r2      <= r1;
        rnd_out <= r2;
        acc     <= ACCW'(sum);
    end

endmodule

// File: rtl/fir_outstage.sv
module fir_outstage
    import fir_cell_pkg::*;
#(
    parameter int ACCW = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             v_in,
    input  rnd_cfg_t         rnd,
    input  logic [ACCW-1:0]  acc_in,
    input  logic [CFG_W-1:0] decim,
    output logic             out_valid,
    output logic [ACCW-1:0]  out_data
);

    logic [CFG_W-1:0]    dcnt, dlim, dnext;
    logic [CFG_W-1:0]    wsel;
    int                  sh;
    logic [ACCW:0]       half;
    logic signed [ACCW:0] biased, shifted;
    logic [ACCW-1:0]     rounded;
    logic                take;

    always_comb begin
        wsel    = clamp_width(rnd.width);
        sh      = ACCW - int'(wsel);
        half    = {{ACCW{1'b0}}, 1'b1} << (sh - 1);
        biased  = $signed({acc_in[ACCW-1], acc_in}) + $signed(half);
        shifted = biased >>> sh;
        rounded = shifted[ACCW-1:0];
    end

    always_comb begin
        dlim  = clamp_decim(decim);
        dnext = ((dcnt + CFG_W'(1)) >= dlim) ? '0 : dcnt + CFG_W'(1);
        take  = v_in && (dcnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dcnt      <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= take;
            if (v_in) begin
                dcnt <= dnext;
            end
            if (take) begin
                out_data <= rnd.en ? rounded : acc_in;
            end
        end
    end

endmodule

// File: rtl/fir_sym_cell.sv
module fir_sym_cell
    import fir_cell_pkg::*;
#(
    parameter int DW   = SAMPLE_W,
    parameter int CW   = COEF_W,
    parameter int NSET = N_SETS,
    parameter int SLEN = SET_LEN,
    parameter int NMUL = N_MUL,
    parameter int ACCW = ACC_W,
    localparam int SELW = $clog2(NSET),
    localparam int IDXW = $clog2(SLEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    input  logic [SELW-1:0]  set_sel,
    input  logic             sym_mode,
    input  logic             data_signed,
    input  logic             coef_signed,
    input  logic             round_en,
    input  logic [CFG_W-1:0] round_width,
    input  logic [CFG_W-1:0] decim,
    input  logic             cw_en,
    input  logic [SELW-1:0]  cw_set,
    input  logic [IDXW-1:0]  cw_idx,
    input  logic [CW-1:0]    cw_data,
    output logic             out_valid,
    output logic [ACCW-1:0]  out_data
);

    lane_ctl_t                  ctl0, ctl1;
    logic [2*NMUL-1:0][DW-1:0]  taps;
    logic [NMUL-1:0][CW-1:0]    coefs;
    logic                       v1, v4;
    rnd_cfg_t                   rnd4;
    logic [ACCW-1:0]            acc4;

    always_comb begin
        ctl0.sym       = sym_mode;
        ctl0.x_sgn     = data_signed;
        ctl0.c_sgn     = coef_signed;
        ctl0.rnd.en    = round_en;
        ctl0.rnd.width = round_width;
    end

    fir_coef_bank #(.CW(CW), .NSET(NSET), .SLEN(SLEN), .NRD(NMUL)) u_bank (
        .clk     (clk),
        .wr_en   (cw_en),
        .wr_set  (cw_set),
        .wr_idx  (cw_idx),
        .wr_data (cw_data),
        .rd_en   (in_valid),
        .rd_set  (set_sel),
        .rd_coef (coefs)
    );

    fir_tapline #(.DW(DW), .NTAP(2*NMUL)) u_taps (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .ctl_in   (ctl0),
        .taps     (taps),
        .v_q      (v1),
        .ctl_q    (ctl1)
    );

    fir_mac #(.DW(DW), .CW(CW), .NMUL(NMUL), .ACCW(ACCW)) u_mac (
        .clk     (clk),
        .rst     (rst),
        .v_in    (v1),
        .ctl_in  (ctl1),
        .taps    (taps),
        .coefs   (coefs),
        .v_out   (v4),
        .rnd_out (rnd4),
        .acc     (acc4)
    );

    fir_outstage #(.ACCW(ACCW)) u_out (
        .clk       (clk),
        .rst       (rst),
        .v_in      (v4),
        .rnd       (rnd4),
        .acc_in    (acc4),
        .decim     (decim),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/fir_sym_cell_chk.sv
module fir_sym_cell_chk
    import fir_cell_pkg::*;
#(
    parameter int ACCW = 28
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             round_en,
    input logic [CFG_W-1:0] round_width,
    input logic [CFG_W-1:0] decim,
    input logic             out_valid,
    input logic [ACCW-1:0]  out_data
);

    logic [2:0] since_rst;
    logic       all_d1;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
            all_d1    <= 1'b1;
        end else begin
            if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
            if (clamp_decim(decim) != CFG_W'(1)) all_d1 <= 1'b0;
        end
    end

    function automatic logic fits_width(input logic [ACCW-1:0] v, input logic [CFG_W-1:0] w);
        logic signed [ACCW-1:0] s;
        s = $signed(v) >>> (clamp_width(w) - CFG_W'(1));
        return (s == '0) || (&s);
    endfunction

    p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_data == '0));

    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (since_rst >= 3'd5 && $past(in_valid, 5)));

    p_full_rate_r8: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd5 && all_d1 && $past(in_valid, 5)) |-> out_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> $stable(out_data));

    p_round_fit_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && since_rst >= 3'd5 && $past(round_en, 5))
            |-> fits_width(out_data, $past(round_width, 5)));

endmodule

bind fir_sym_cell fir_sym_cell_chk #(.ACCW(ACCW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .round_en    (round_en),
    .round_width (round_width),
    .decim       (decim),
    .out_valid   (out_valid),
    .out_data    (out_data)
);

// File: tb/sim_fir_sym_cell.sv
module sim_fir_sym_cell;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst, in_valid, sym_mode, data_signed, coef_signed, round_en, cw_en;
    logic [9:0]  in_data, cw_data;
    logic [4:0]  set_sel, round_width, decim, cw_set;
    logic [2:0]  cw_idx;
    logic        out_valid;
    logic [27:0] out_data;

    fir_sym_cell u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .set_sel(set_sel),
        .sym_mode(sym_mode), .data_signed(data_signed), .coef_signed(coef_signed),
        .round_en(round_en), .round_width(round_width), .decim(decim),
        .cw_en(cw_en), .cw_set(cw_set), .cw_idx(cw_idx), .cw_data(cw_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    typedef struct { int e; logic [27:0] d; } exp_t;
    exp_t        q[$];
    int          mem [32][8];
    int          hist [8];
    int          dcnt = 0;
    int          edge_no = 0;
    int          total = 0, bad = 0;
    logic [27:0] last_out = '0;
    string       tag = "R10";
    bit          finished = 0;

    function automatic longint sx(input int raw, input bit sg);
        return (sg && raw[9]) ? longint'(raw - 1024) : longint'(raw);
    endfunction

    task automatic check(input bit ok, input string t, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h (edge %0d)", t, what, act, exp, edge_no);
        end
    endtask

    task automatic cyc();
        bit     rst_now, expv;
        longint acc, xs, r;
        int     d, w, sh;
        rst_now = rst;
        if (rst) begin
            foreach (hist[k]) hist[k] = 0;
            q.delete();
            dcnt = 0;
        end else if (in_valid) begin
            for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = int'(in_data);
            acc = 0;
            for (int k = 0; k < 4; k++) begin
                xs = sx(hist[k], data_signed) + (sym_mode ? sx(hist[7-k], data_signed) : 0);
                acc += sx(mem[set_sel][k], coef_signed) * xs;
            end
            if (round_en) begin
                w  = (round_width < 8) ? 8 : (round_width > 19 ? 19 : int'(round_width));
                sh = 28 - w;
                r  = (acc + (longint'(1) <<< (sh - 1))) >>> sh;
            end else begin
                r = acc;
            end
            d = (decim == 0) ? 1 : (decim > 16 ? 16 : int'(decim));
            if (dcnt == 0) q.push_back('{edge_no + 5, r[27:0]});
            dcnt = (dcnt + 1 >= d) ? 0 : dcnt + 1;
        end
        if (cw_en) mem[cw_set][cw_idx] = int'(cw_data);
        @(posedge clk);
        edge_no++;
        @(negedge clk);
        expv = 0;
        if (rst_now) begin
            last_out = '0;
        end else if (q.size() > 0 && q[0].e == edge_no) begin
            expv = 1;
            last_out = q[0].d;
            void'(q.pop_front());
        end
        check(out_valid === expv, tag, "out_valid", longint'(out_valid), longint'(expv));
        check(out_data === last_out, tag, "out_data", longint'(out_data), longint'(last_out));
    endtask

    function automatic logic [9:0] samp(input int pat, input int i);
        case (pat)
            0:       return (i == 0) ? 10'd1 : 10'd0;
            1:       return 10'((i * 137 + 61) % 1024);
            2:       return (i % 2) ? 10'h3FF : 10'h200;
            default: return (i % 3 == 0) ? 10'h1FF : ((i % 3 == 1) ? 10'h200 : 10'h3FF);
        endcase
    endfunction

    task automatic stream(input int n, input int pat, input int sel, input bit gaps, input bit rot);
        for (int i = 0; i < n; i++) begin
            in_valid = gaps ? (i % 4 != 3) : 1'b1;
            in_data  = samp(pat, i);
            set_sel  = rot ? 5'(i % 32) : 5'(sel);
            cyc();
        end
        in_valid = 1'b0;
        repeat (6) cyc();
    endtask

    task automatic do_reset(input int n);
        rst = 1'b1;
        repeat (n) cyc();
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; in_valid = 0; in_data = '0; set_sel = '0; sym_mode = 1;
        data_signed = 0; coef_signed = 0; round_en = 0; round_width = 5'd19; decim = 5'd1;
        cw_en = 0; cw_set = '0; cw_idx = '0; cw_data = '0;
        foreach (hist[k]) hist[k] = 0;
        foreach (mem[s, i]) mem[s][i] = 0;

        tag = "R10";
        repeat (3) cyc();
        rst = 1'b0;
        check(out_valid == 1'b0 && out_data == '0, "R10", "reset outputs",
              longint'(out_data), 0);

        // R4: load every set; words 4..7 get large values that must not matter
        tag = "R4";
        for (int s = 0; s < 32; s++) begin
            for (int i = 0; i < 8; i++) begin
                cw_en = 1; cw_set = 5'(s); cw_idx = 3'(i);
                cw_data = (i >= 4) ? 10'h3FF : 10'((s * 73 + i * 29 + 5) % 1024);
                cyc();
            end
        end
        cw_en = 0;

        tag = "R2/R6";
        sym_mode = 1;
        stream(12, 0, 0, 0, 0);
        stream(20, 1, 3, 0, 0);

        tag = "R3/R6";
        sym_mode = 0;
        stream(20, 1, 7, 0, 0);
        stream(16, 2, 9, 0, 0);

        tag = "R1";
        sym_mode = 1; data_signed = 1; coef_signed = 1;
        stream(18, 3, 11, 0, 0);
        data_signed = 1; coef_signed = 0;
        stream(18, 2, 12, 0, 0);
        data_signed = 0; coef_signed = 1;
        stream(18, 3, 13, 0, 0);

        tag = "R5";
        data_signed = 1; coef_signed = 1;
        stream(40, 1, 0, 0, 1);

        tag = "R4";
        for (int i = 0; i < 12; i++) begin
            in_valid = 1; in_data = samp(1, i); set_sel = 5'd2;
            cw_en = (i == 5); cw_set = 5'd2; cw_idx = 3'd1; cw_data = 10'h155;
            cyc();
        end
        cw_en = 0; in_valid = 0;
        repeat (6) cyc();

        tag = "R7";
        round_en = 1;
        for (int j = 0; j < 5; j++) begin
            round_width = (j == 0) ? 5'd8 : (j == 1) ? 5'd13 : (j == 2) ? 5'd19 : (j == 3) ? 5'd3 : 5'd25;
            stream(14, 3, 20 + j, 0, 0);
        end
        round_en = 0;

        tag = "R8";
        for (int j = 0; j < 4; j++) begin
            decim = (j == 0) ? 5'd3 : (j == 1) ? 5'd16 : (j == 2) ? 5'd0 : 5'd20;
            do_reset(1);
            stream(40, 1, 4, 0, 0);
        end

        tag = "R9";
        decim = 5'd2;
        do_reset(1);
        stream(30, 3, 6, 1, 0);
        decim = 5'd1;

        tag = "R10";
        for (int i = 0; i < 6; i++) begin
            in_valid = 1; in_data = samp(2, i); set_sel = 5'd8;
            cyc();
        end
        do_reset(2);
        stream(14, 1, 8, 0, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog %s actual=hung expected=done", tag);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule